// File: doc/BRIEF.md
# Snooping Write-Back Coherence Controller

This block sits beside one private cache in a small shared-bus multiprocessor and keeps that cache coherent with its peers. It holds a direct-mapped array of blocks; each entry carries a tag, a one-word data payload and a coherence state of Invalid, Shared (clean, read-only) or Exclusive (sole copy, writable, dirty). Memory is written back lazily, and writes gain ownership by invalidating every other copy.

The processor side is a request/ready port. Hits finish in the cycle they are presented. Misses stall the processor while the controller raises bus requests and waits for grants. A dirty block that must be replaced is written back first. The snoop side watches transactions from other caches. On a hit to a dirty block it flushes the data and tells memory to abort its own reply. The bus is atomic, so a grant completes a whole transaction in one cycle and never coincides with a snoop.

Top module: `snoop_wb_ctrl`

## Requirements
- R1: After reset every block is Invalid. The first access to any address goes to the bus, and `cpuReady`, `busReq`, `snpWb` and `memAbort` are all low while idle.
- R2: A processor read to an Invalid block, or to a clean block with another tag, raises one read-miss transaction (`busCmd`=1) at the requested address and returns `busRdata`. The block becomes Shared, so a repeated read causes no bus traffic.
- R3: A processor write to an Invalid or Shared block raises one write-miss transaction (`busCmd`=2) and leaves the block Exclusive. Later writes and reads to it use no bus.
- R4: A miss whose index holds an Exclusive block with another tag first raises a write-back (`busCmd`=3), carrying the old block's address and data. Only then is the read or write miss raised.
- R5: A snooped read miss (`snpCmd`=1) that hits an Exclusive block raises `snpWb` and `memAbort` in the same cycle, with the block's data on `snpData`. The block becomes Shared: a later read hits, and a later write needs a write miss.
- R6: A snooped write miss (`snpCmd`=2) that hits an Exclusive block flushes it as in R5 and leaves it Invalid. If it hits a Shared block, the block becomes Invalid without a flush.
- R7: Read hits in Shared or Exclusive, and write hits in Exclusive, raise `cpuReady` in the first cycle of the request and raise no bus request.
- R8: A missing request keeps `cpuReady` low until its final transaction is granted. `cpuReady` rises in the grant cycle.
- R9: A snoop has priority over the processor on the same index in the same cycle. If a snoop removes a dirty victim while its write-back is still waiting, the write-back is dropped and only the miss is raised.
- R10: A snoop whose tag does not match, or that finds the block Invalid, changes nothing: no flush, no abort, and the resident block keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request valid, held until `cpuReady` |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address; low IDX_W bits select the block |
| cpuWdata | input | DATA_W | Write data |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | DATA_W | Read data, valid with `cpuReady` on reads |
| busReq | output | 1 | Bus transaction requested |
| busCmd | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| busAddr | output | ADDR_W | Address of the requested transaction |
| busWdata | output | DATA_W | Data for a write-back |
| busGnt | input | 1 | Requested transaction completes this cycle |
| busRdata | input | DATA_W | Fill data returned with a granted miss |
| snpValid | input | 1 | Another cache's transaction is on the bus |
| snpCmd | input | 2 | Snooped command: 1 read miss, 2 write miss |
| snpAddr | input | ADDR_W | Snooped address |
| snpWb | output | 1 | This cache flushes the dirty block in place of memory |
| snpData | output | DATA_W | Flushed data |
| memAbort | output | 1 | Memory must drop its reply to the snooped request |

## Verification
The hardest case to reach is a snoop landing in the narrow window where a miss has already picked a dirty victim but its write-back has not been granted. A second hard case is a snoop and a processor hit reaching the same block in one cycle. The stimulus reaches both by holding the grant back for a set number of cycles and injecting a snoop at a chosen cycle of the processor request. The bench then counts the bus transactions that follow and checks which ones were dropped.

// File: rtl/snoop_wb_pkg.sv
package snoop_wb_pkg;
  typedef enum logic [1:0] {BLK_INV = 2'd0, BLK_SHR = 2'd1, BLK_EXC = 2'd2} blkState_e;

  localparam logic [1:0] CMD_NONE   = 2'd0;
  localparam logic [1:0] CMD_RDMISS = 2'd1;
  localparam logic [1:0] CMD_WRMISS = 2'd2;
  localparam logic [1:0] CMD_WBACK  = 2'd3;

  typedef struct packed {
    logic wrHit;      // local write into an owned block
    logic victimInv;  // dirty victim written back, drop it
    logic fill;       // miss granted, install the block
    logic fillExc;    // install as owned with processor data
  } ctlStrobe_t;
endpackage

// File: rtl/snoop_wb_datapath.sv
module snoop_wb_datapath
  import snoop_wb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  ctlStrobe_t        strobe,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output blkState_e         cpuState,
  output logic              cpuTagMatch,
  output logic [DATA_W-1:0] cpuData,
  output logic [ADDR_W-1:0] victimAddr,
  output logic              snpWb,
  output logic [DATA_W-1:0] snpData
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int NBLK  = 2 ** IDX_W;

  blkState_e         stateQ [NBLK];
  logic [TAG_W-1:0]  tagQ   [NBLK];
  logic [DATA_W-1:0] dataQ  [NBLK];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  logic             snpMatch;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  assign cpuState    = stateQ[cpuIdx];
  assign cpuTagMatch = (tagQ[cpuIdx] == cpuTag);
  assign cpuData     = dataQ[cpuIdx];
  assign victimAddr  = {tagQ[cpuIdx], cpuIdx};

  assign snpMatch = snpValid && (stateQ[snpIdx] != BLK_INV) && (tagQ[snpIdx] == snpTag);
  assign snpWb    = snpMatch && (stateQ[snpIdx] == BLK_EXC) &&
                    ((snpCmd == CMD_RDMISS) || (snpCmd == CMD_WRMISS));
  assign snpData  = dataQ[snpIdx];

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    logic snpHere, cpuHere;
    assign snpHere = snpMatch && (snpIdx == IDX_W'(i));
    assign cpuHere = (cpuIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stateQ[i] <= BLK_INV;
      end else if (snpHere) begin
        if (snpCmd == CMD_WRMISS)
          stateQ[i] <= BLK_INV;
        else if (snpCmd == CMD_RDMISS && stateQ[i] == BLK_EXC)
          stateQ[i] <= BLK_SHR;
      end else if (cpuHere) begin
        if (strobe.fill)
          stateQ[i] <= strobe.fillExc ? BLK_EXC : BLK_SHR;
        else if (strobe.victimInv)
          stateQ[i] <= BLK_INV;
      end
    end

    always_ff @(posedge clk) begin
      if (cpuHere && !snpHere) begin
        if (strobe.fill) begin
          tagQ[i]  <= cpuTag;
          dataQ[i] <= strobe.fillExc ? cpuWdata : busRdata;
        end else if (strobe.wrHit) begin
          dataQ[i] <= cpuWdata;
        end
      end
    end
  end
endmodule

// File: rtl/snoop_wb_control.sv
module snoop_wb_control
  import snoop_wb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  blkState_e         cpuState,
  input  logic              cpuTagMatch,
  input  logic              busGnt,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  output ctlStrobe_t        strobe,
  output logic              cpuReady,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic              wbPhase,
  output logic              fromBus
);
  typedef enum logic [1:0] {PH_IDLE, PH_WB, PH_MISS} phase_e;

  phase_e phQ, phNxt;
  logic   snoopClash, hitOk, dirtyVictim;

  assign snoopClash  = snpValid && (snpAddr[IDX_W-1:0] == cpuAddr[IDX_W-1:0]);
  assign hitOk       = cpuTagMatch &&
                       ((cpuState == BLK_EXC) || (cpuState == BLK_SHR && !cpuWe));
  assign dirtyVictim = (cpuState == BLK_EXC) && !cpuTagMatch;

  always_comb begin
    phNxt    = phQ;
    strobe   = '0;
    cpuReady = 1'b0;
    busReq   = 1'b0;
    busCmd   = CMD_NONE;
    wbPhase  = 1'b0;
    fromBus  = 1'b0;
    case (phQ)
      PH_IDLE: begin
        if (cpuReq && !snoopClash) begin
          if (hitOk) begin
            cpuReady     = 1'b1;
            strobe.wrHit = cpuWe;
          end else if (dirtyVictim) begin
            phNxt = PH_WB;
          end else begin
            phNxt = PH_MISS;
          end
        end
      end
      PH_WB: begin
        if (dirtyVictim) begin
          busReq  = 1'b1;
          busCmd  = CMD_WBACK;
          wbPhase = 1'b1;
          if (busGnt) begin
            strobe.victimInv = 1'b1;
            phNxt            = PH_MISS;
          end
        end else begin
          phNxt = PH_MISS;
        end
      end
      PH_MISS: begin
        busReq = 1'b1;
        busCmd = cpuWe ? CMD_WRMISS : CMD_RDMISS;
        if (busGnt) begin
          strobe.fill    = 1'b1;
          strobe.fillExc = cpuWe;
          cpuReady       = 1'b1;
          fromBus        = 1'b1;
          phNxt          = PH_IDLE;
        end
      end
      default: phNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phQ <= PH_IDLE;
    else       phQ <= phNxt;
  end
endmodule

// File: rtl/snoop_wb_ctrl.sv
module snoop_wb_ctrl
  import snoop_wb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busGnt,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpWb,
  output logic [DATA_W-1:0] snpData,
  output logic              memAbort
);
  ctlStrobe_t        strobe;
  blkState_e         cpuState;
  logic              cpuTagMatch, wbPhase, fromBus;
  logic [DATA_W-1:0] cpuData;
  logic [ADDR_W-1:0] victimAddr;

  snoop_wb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .busRdata(busRdata), .strobe(strobe), .snpValid(snpValid),
    .snpCmd(snpCmd), .snpAddr(snpAddr), .cpuState(cpuState),
    .cpuTagMatch(cpuTagMatch), .cpuData(cpuData), .victimAddr(victimAddr),
    .snpWb(snpWb), .snpData(snpData)
  );

  snoop_wb_control #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuState(cpuState), .cpuTagMatch(cpuTagMatch), .busGnt(busGnt),
    .snpValid(snpValid), .snpAddr(snpAddr), .strobe(strobe),
    .cpuReady(cpuReady), .busReq(busReq), .busCmd(busCmd),
    .wbPhase(wbPhase), .fromBus(fromBus)
  );

  assign cpuRdata = fromBus ? busRdata : cpuData;
  assign busAddr  = wbPhase ? victimAddr : cpuAddr;
  assign busWdata = cpuData;
  assign memAbort = snpWb;
endmodule

// File: rtl/snoop_wb_ctrl_chk.sv
module snoop_wb_ctrl_chk
  import snoop_wb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReady,
  input logic              busReq,
  input logic [1:0]        busCmd,
  input logic              busGnt,
  input logic              snpValid,
  input logic [1:0]        snpCmd,
  input logic [ADDR_W-1:0] snpAddr,
  input logic              snpWb,
  input logic              memAbort
);
  a_r8_no_ready_while_waiting: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt) |-> !cpuReady);

  a_r7_hit_stays_off_bus: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && !busGnt) |-> !busReq);

  a_r4_miss_follows_wback: assert property (@(posedge clk) disable iff (!rstN)
    (busGnt && busReq && busCmd == CMD_WBACK) |=> (busReq && busCmd != CMD_WBACK));

  a_r10_quiet_without_snoop: assert property (@(posedge clk) disable iff (!rstN)
    !snpValid |-> (!snpWb && !memAbort));

  a_r5_flush_aborts_memory: assert property (@(posedge clk) disable iff (!rstN)
    snpWb |-> memAbort);

  a_r6_single_flush: assert property (@(posedge clk) disable iff (!rstN)
    (snpWb && snpCmd == CMD_WRMISS) ##1 (snpValid && snpAddr == $past(snpAddr)) |-> !snpWb);

  a_r3_request_has_command: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busCmd != CMD_NONE);

  a_r9_atomic_bus: assert property (@(posedge clk) disable iff (!rstN)
    !(snpValid && busGnt));
endmodule

bind snoop_wb_ctrl snoop_wb_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuReady(cpuReady), .busReq(busReq), .busCmd(busCmd),
  .busGnt(busGnt), .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
  .snpWb(snpWb), .memAbort(memAbort)
);

// File: tb/snoop_wb_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_wb_ctrl_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpuReq = 0, cpuWe = 0, cpuReady, busReq, busGnt = 0, snpValid = 0, snpWb, memAbort;
  logic [ADDR_W-1:0] cpuAddr = '0, busAddr, snpAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0, cpuRdata, busWdata, busRdata = '0, snpData;
  logic [1:0] busCmd, snpCmd = 2'd0;

  always #2 clk = ~clk;

  snoop_wb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(2)) u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr), .busWdata(busWdata),
    .busGnt(busGnt), .busRdata(busRdata), .snpValid(snpValid), .snpCmd(snpCmd),
    .snpAddr(snpAddr), .snpWb(snpWb), .snpData(snpData), .memAbort(memAbort)
  );

  int checks = 0, failures = 0, otherSeq = 0;
  logic [DATA_W-1:0] mem [256];
  logic [DATA_W-1:0] golden [256];

  // results of the last operation
  logic [DATA_W-1:0] gotRdata, flushData;
  int txnCnt, readyK;
  logic [1:0] firstCmd;
  logic [7:0] firstAddr;
  logic flushSeen, abortSeen;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // snoop effect on the bench memory and the expected values
  task automatic applySnoop(input logic [1:0] cmd, input logic [7:0] a);
    if (snpWb) mem[a] = snpData;
    if (cmd == 2'd2) begin
      otherSeq++;
      golden[a] = 32'hC0DE_0000 | (otherSeq << 8) | a;
      mem[a]    = golden[a];
    end
  endtask

  task automatic cpuOp(input logic we, input logic [7:0] a, input logic [31:0] wd,
                       input int gw, input int injK, input logic [1:0] injCmd,
                       input logic [7:0] injAddr);
    bit done = 0;
    int k = 0;
    txnCnt = 0; readyK = -1; firstCmd = 0; firstAddr = 0;
    flushSeen = 0; abortSeen = 0; flushData = 0;
    @(negedge clk);
    cpuReq = 1; cpuWe = we; cpuAddr = {8'h00, a}; cpuWdata = wd;
    while (!done) begin
      #0.5;
      if (k == injK) begin
        snpValid = 1; snpCmd = injCmd; snpAddr = {8'h00, injAddr};
      end
      #0.25;
      if (busReq && k >= gw && k != injK) begin
        busGnt = 1;
        if (txnCnt == 0) begin firstCmd = busCmd; firstAddr = busAddr[7:0]; end
        txnCnt++;
        if (busCmd == 2'd3) mem[busAddr[7:0]] = busWdata;
        else busRdata = mem[busAddr[7:0]];
      end
      #0.25;
      if (k == injK) begin
        flushSeen = snpWb; abortSeen = memAbort; flushData = snpData;
        applySnoop(injCmd, injAddr);
      end
      if (cpuReady) begin done = 1; readyK = k; gotRdata = cpuRdata; end
      @(negedge clk);
      busGnt = 0; snpValid = 0;
      if (done) cpuReq = 0;
      k++;
      if (k > 40) begin
        check("watchdog op", 0, 1);
        finishRun();
      end
    end
    if (we) begin golden[a] = wd; end
  endtask

  task automatic snoopOnly(input logic [1:0] cmd, input logic [7:0] a);
    @(negedge clk);
    snpValid = 1; snpCmd = cmd; snpAddr = {8'h00, a};
    #1;
    flushSeen = snpWb; abortSeen = memAbort; flushData = snpData;
    applySnoop(cmd, a);
    @(negedge clk);
    snpValid = 0;
  endtask

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [1:0]  expCnt;
    logic [1:0]  expCmd;
    logic [7:0]  expAddr;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 8'h10, 32'h0,         2'd1, 2'd1, 8'h10},  // R1 R2 cold read miss
    '{1'b0, 8'h10, 32'h0,         2'd0, 2'd0, 8'h00},  // R7 read hit Shared
    '{1'b1, 8'h10, 32'h1111_0001, 2'd1, 2'd2, 8'h10},  // R3 write to Shared
    '{1'b0, 8'h10, 32'h0,         2'd0, 2'd0, 8'h00},  // R7 read hit Exclusive
    '{1'b1, 8'h10, 32'h1111_0002, 2'd0, 2'd0, 8'h00},  // R7 write hit Exclusive
    '{1'b0, 8'h14, 32'h0,         2'd2, 2'd3, 8'h10},  // R4 dirty victim then read
    '{1'b0, 8'h10, 32'h0,         2'd1, 2'd1, 8'h10},  // R2 clean victim, data written back
    '{1'b1, 8'h21, 32'h2222_0001, 2'd1, 2'd2, 8'h21},  // R3 write to Invalid
    '{1'b1, 8'h25, 32'h2222_0002, 2'd2, 2'd3, 8'h21},  // R4 dirty victim then write
    '{1'b0, 8'h21, 32'h0,         2'd2, 2'd3, 8'h25},  // R4 victim address check
    '{1'b1, 8'h33, 32'h3333_0001, 2'd1, 2'd2, 8'h33},  // R3 write miss
    '{1'b0, 8'h33, 32'h0,         2'd0, 2'd0, 8'h00}   // R7 read own write
  };

  initial begin
    #800000;
    check("watchdog global", 0, 1);
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'hA000_0000 | i;
      golden[i] = mem[i];
    end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    check("R1 ready idle", cpuReady, 0);
    check("R1 busReq idle", busReq, 0);
    check("R1 flush idle", snpWb, 0);
    check("R1 abort idle", memAbort, 0);

    // R1 R10: snoop against an empty array
    snoopOnly(2'd1, 8'h10);
    check("R10 no flush after reset", flushSeen, 0);
    check("R10 no abort after reset", abortSeen, 0);

    foreach (VECS[i]) begin
      cpuOp(VECS[i].we, VECS[i].addr, VECS[i].wdata, 0, -1, 2'd0, 8'h00);
      check($sformatf("R2 R3 R4 R7 row%0d bus count", i), txnCnt, VECS[i].expCnt);
      if (VECS[i].expCnt != 0) begin
        check($sformatf("R2 R3 R4 row%0d first cmd", i), firstCmd, VECS[i].expCmd);
        check($sformatf("R4 row%0d first addr", i), firstAddr, VECS[i].expAddr);
      end else begin
        check($sformatf("R7 row%0d ready in first cycle", i), readyK, 0);
      end
      if (!VECS[i].we)
        check($sformatf("R2 row%0d read data", i), gotRdata, golden[VECS[i].addr]);
    end

    // R5: snooped read miss on an owned block
    cpuOp(1, 8'h42, 32'h4444_0001, 0, -1, 2'd0, 8'h00);
    snoopOnly(2'd1, 8'h42);
    check("R5 flush", flushSeen, 1);
    check("R5 abort", abortSeen, 1);
    check("R5 flush data", flushData, 32'h4444_0001);
    cpuOp(0, 8'h42, 0, 0, -1, 2'd0, 8'h00);
    check("R5 read hits after downgrade", txnCnt, 0);
    check("R5 read data", gotRdata, 32'h4444_0001);
    cpuOp(1, 8'h42, 32'h4444_0002, 0, -1, 2'd0, 8'h00);
    check("R5 write needs miss", txnCnt, 1);
    check("R5 write miss cmd", firstCmd, 2'd2);

    // R6: snooped write miss on owned, then on shared
    snoopOnly(2'd2, 8'h42);
    check("R6 owned flush", flushSeen, 1);
    check("R6 owned abort", abortSeen, 1);
    check("R6 owned flush data", flushData, 32'h4444_0002);
    cpuOp(0, 8'h42, 0, 0, -1, 2'd0, 8'h00);
    check("R6 invalidated read misses", txnCnt, 1);
    check("R6 new value read", gotRdata, golden[8'h42]);
    snoopOnly(2'd2, 8'h42);
    check("R6 shared no flush", flushSeen, 0);
    check("R6 shared no abort", abortSeen, 0);
    cpuOp(0, 8'h42, 0, 0, -1, 2'd0, 8'h00);
    check("R6 shared invalidated", txnCnt, 1);
    check("R6 shared new value", gotRdata, golden[8'h42]);

    // R10: snoop with another tag on the same index
    snoopOnly(2'd2, 8'h46);
    check("R10 tag miss no flush", flushSeen, 0);
    cpuOp(0, 8'h42, 0, 0, -1, 2'd0, 8'h00);
    check("R10 block kept", txnCnt, 0);

    // R9: snoop removes the dirty victim while its write-back waits
    cpuOp(1, 8'h57, 32'h5555_0001, 3, 1, 2'd2, 8'h33);
    check("R9 victim flushed by snoop", flushSeen, 1);
    check("R9 victim flush data", flushData, 32'h3333_0001);
    check("R9 write-back dropped", txnCnt, 1);
    check("R9 only write miss", firstCmd, 2'd2);
    check("R9 miss address", firstAddr, 8'h57);

    // R9: same-cycle snoop wins over a write hit
    cpuOp(1, 8'h57, 32'h5555_0002, 0, 0, 2'd1, 8'h57);
    check("R9 snoop flushes old data", flushData, 32'h5555_0001);
    check("R9 write falls to miss", txnCnt, 1);
    check("R9 write miss cmd", firstCmd, 2'd2);
    check("R9 write ready cycle", readyK, 2);
    cpuOp(0, 8'h57, 0, 0, -1, 2'd0, 8'h00);
    check("R9 new data kept", gotRdata, 32'h5555_0002);

    // R8: stall until grant
    cpuOp(0, 8'h60, 0, 3, -1, 2'd0, 8'h00);
    check("R8 ready at grant cycle", readyK, 3);
    check("R8 fill data", gotRdata, golden[8'h60]);

    finishRun();
  end
endmodule